// File: doc/BRIEF.md
# Zone-Coded Storage Address Register

This register holds a storage address in the three-character decimal form that a character-serial machine uses: a hundreds, a tens and a units digit, each a six-bit character made of two zone bits (B, A) over a four-bit numeric code. The zone pair over the hundreds digit selects one of four thousand-blocks, and the zone pair over the units digit selects one of four four-thousand-blocks. Together they reach linear positions 0 to 15999.

The register can take a whole three-character address, step up by one (as when instruction characters are fetched) or step down by one (as when a data field is walked from its low-order end). A step carries or borrows through the units, tens and hundreds digits and on into both zone pairs. The stepped value is written back out in zone-coded form. Every cycle the register also reports the linear position. It raises an invalid flag when the address holds an illegal character code or points above the installed storage size. It raises a one-cycle end-around flag when a step wraps past either end of the full range.

Top module: `zaddr_reg`

## Requirements
- R1: After a synchronous reset, lin_addr is 0, addr_chars encodes 000 with no zone bits (each digit code 1010), and bad_addr and end_around are 0.
- R2: On load, character layout is hundreds in ld_addr[17:12], tens in [11:6], units in [5:0]. Within each character, bit 5 is zone B, bit 4 is zone A, and bits 3:0 are the numeric code. Code 1010 means 0 and codes 0001 to 1001 mean 1 to 9. The hundreds zone pair {B,A} adds 0, 1000, 2000 or 3000 for values 00, 01, 10 and 11.
- R3: The units zone pair {B,A} adds 0, 4000, 8000 or 12000 for values 00, 01, 10 and 11.
- R4: inc raises lin_addr by one. The carry passes through the three digits and both zone pairs, and addr_chars is re-encoded to match the new value.
- R5: dec lowers lin_addr by one, with the borrow passing through digits and zones, and addr_chars is re-encoded to match.
- R6: inc at 15999 gives 0 and dec at 0 gives 15999. end_around is 1 for exactly the cycle that shows the wrapped value, and 0 after any other operation or idle cycle.
- R7: A loaded numeric code of 0000 or 1011 to 1111, or a nonzero zone on the tens character, sets bad_addr. Such a code counts as digit value 0. The next inc or dec clears this cause.
- R8: size_sel values 0, 1, 2 and 3 install 4000, 8000, 12000 and 16000 positions. bad_addr is set whenever the units zone value exceeds size_sel. It is re-evaluated at every clock edge using the current size_sel.
- R9: ld has priority over inc, and inc has priority over dec. With none of the three asserted, the address holds.
- R10: All outputs are registered and change at the clock edge that samples the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Load ld_addr |
| ld_addr | input | 18 | Three zone-coded address characters |
| inc | input | 1 | Step up by one |
| dec | input | 1 | Step down by one |
| size_sel | input | 2 | Installed storage size code |
| lin_addr | output | 14 | Linear storage position |
| addr_chars | output | 18 | Current address in zone-coded form |
| bad_addr | output | 1 | Illegal code or address above installed size |
| end_around | output | 1 | A step wrapped past either end of the range |

## Verification
The register keeps its state as five mixed-radix fields, so a wrong carry or borrow at a digit or zone boundary shows up as a jump of 10, 100, 1000 or 4000 on lin_addr. It also shows as a mismatched character on addr_chars, at the edge after the step. The tests therefore step across 999/1000, 3999/4000 and both ends of the range. A stale illegal-digit state or a wrong size comparison shows on bad_addr one edge after the load, step or size change that should have altered it.

// File: rtl/zaddr_pkg.sv
package zaddr_pkg;
  localparam int NDIG = 3;            // decimal digit characters
  localparam int NZON = 2;            // zone pairs (hundreds, units)
  localparam int NPOS = NDIG + NZON;  // mixed-radix positions
  localparam int CW   = 6;            // character width: B A 8 4 2 1
  localparam int FW   = 4;            // field width
  localparam int SW   = 2;            // size select width

  typedef logic [NDIG-1:0][CW-1:0] chars_t;
  typedef logic [NPOS-1:0][FW-1:0] fields_t;

  // position 0..NDIG-1 decimal digits, NDIG hundreds zone, NDIG+1 units zone
  function automatic int radix(int i);
    return (i < NDIG) ? 10 : 4;
  endfunction

  function automatic int weight(int i);
    int w;
    w = 1;
    for (int k = 0; k < i; k++) w = w * radix(k);
    return w;
  endfunction

  localparam int TOTAL = weight(NPOS);
  localparam int LW    = $clog2(TOTAL);

  function automatic logic code_ok(logic [3:0] n);
    return (n >= 4'd1) && (n <= 4'd10);
  endfunction

  function automatic logic [FW-1:0] code_to_val(logic [3:0] n);
    return (n >= 4'd1 && n <= 4'd9) ? FW'(n) : '0;
  endfunction

  function automatic logic [3:0] val_to_code(logic [FW-1:0] v);
    return (v == '0) ? 4'd10 : 4'(v);
  endfunction
endpackage

// File: rtl/zaddr_decode.sv
module zaddr_decode
  import zaddr_pkg::*;
(
  input  chars_t  chars,
  output fields_t fld,
  output logic    illegal
);
  logic [NDIG-1:0] ok;
  logic [NDIG-1:0] zmid;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    assign fld[i] = code_to_val(chars[i][3:0]);
    assign ok[i]  = code_ok(chars[i][3:0]);
    if (i == 0 || i == NDIG-1) begin : g_edge
      assign zmid[i] = 1'b0;
    end else begin : g_mid
      assign zmid[i] = |chars[i][5:4];
    end
  end

  assign fld[NDIG]   = FW'(chars[NDIG-1][5:4]);
  assign fld[NDIG+1] = FW'(chars[0][5:4]);
  assign illegal     = ~(&ok) | (|zmid);
endmodule

// File: rtl/zaddr_step.sv
module zaddr_step
  import zaddr_pkg::*;
#(
  parameter bit UP = 1'b1
) (
  input  fields_t fld,
  output fields_t nxt,
  output logic    wrap
);
  always_comb begin
    logic c;
    c = 1'b1;
    for (int i = 0; i < NPOS; i++) begin
      nxt[i] = fld[i];
      if (c) begin
        if (UP) begin
          if (fld[i] == FW'(radix(i) - 1)) nxt[i] = '0;
          else begin
            nxt[i] = fld[i] + FW'(1);
            c = 1'b0;
          end
        end else begin
          if (fld[i] == '0) nxt[i] = FW'(radix(i) - 1);
          else begin
            nxt[i] = fld[i] - FW'(1);
            c = 1'b0;
          end
        end
      end
    end
    wrap = c;
  end
endmodule

// File: rtl/zaddr_pack.sv
module zaddr_pack
  import zaddr_pkg::*;
(
  input  fields_t         fld,
  output logic [LW-1:0]   lin,
  output chars_t          chars
);
  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < NPOS; i++) acc = acc + int'(fld[i]) * weight(i);
    lin = LW'(acc);
  end

  for (genvar i = 0; i < NDIG; i++) begin : g_enc
    if (i == NDIG-1) begin : g_hund
      assign chars[i] = {2'(fld[NDIG]), val_to_code(fld[i])};
    end else if (i == 0) begin : g_unit
      assign chars[i] = {2'(fld[NDIG+1]), val_to_code(fld[i])};
    end else begin : g_mid
      assign chars[i] = {2'b00, val_to_code(fld[i])};
    end
  end
endmodule

// File: rtl/zaddr_reg.sv
module zaddr_reg
  import zaddr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld,
  input  logic [NDIG*CW-1:0]   ld_addr,
  input  logic                 inc,
  input  logic                 dec,
  input  logic [SW-1:0]        size_sel,
  output logic [LW-1:0]        lin_addr,
  output logic [NDIG*CW-1:0]   addr_chars,
  output logic                 bad_addr,
  output logic                 end_around
);
  fields_t fld_q, fld_ld, fld_up, fld_dn, fld_n;
  logic    ill_ld, wrap_up, wrap_dn;
  logic    ill_q, ill_n, ea_n;
  logic [LW-1:0] lin_n;
  chars_t  chars_n;

  zaddr_decode u_dec (.chars(chars_t'(ld_addr)), .fld(fld_ld), .illegal(ill_ld));
  zaddr_step #(.UP(1'b1)) u_up (.fld(fld_q), .nxt(fld_up), .wrap(wrap_up));
  zaddr_step #(.UP(1'b0)) u_dn (.fld(fld_q), .nxt(fld_dn), .wrap(wrap_dn));

  always_comb begin
    fld_n = fld_q;
    ill_n = ill_q;
    ea_n  = 1'b0;
    if (ld) begin
      fld_n = fld_ld;
      ill_n = ill_ld;
    end else if (inc) begin
      fld_n = fld_up;
      ill_n = 1'b0;
      ea_n  = wrap_up;
    end else if (dec) begin
      fld_n = fld_dn;
      ill_n = 1'b0;
      ea_n  = wrap_dn;
    end
  end

  zaddr_pack u_pack (.fld(fld_n), .lin(lin_n), .chars(chars_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q      <= '0;
      ill_q      <= 1'b0;
      lin_addr   <= '0;
      addr_chars <= {NDIG{2'b00, 4'd10}};
      bad_addr   <= 1'b0;
      end_around <= 1'b0;
    end else begin
      fld_q      <= fld_n;
      ill_q      <= ill_n;
      lin_addr   <= lin_n;
      addr_chars <= chars_n;
      bad_addr   <= ill_n | (fld_n[NDIG+1] > FW'(size_sel));
      end_around <= ea_n;
    end
  end

  // R4: step up by one away from the top
  p_inc_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!ld && inc && lin_addr != LW'(TOTAL-1)) |=> (lin_addr == $past(lin_addr) + LW'(1)));
  // R5: step down by one away from zero
  p_dec_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!ld && !inc && dec && lin_addr != '0) |=> (lin_addr == $past(lin_addr) - LW'(1)));
  // R6: wrap at either end raises end_around
  p_wrap_up_r6: assert property (@(posedge clk) disable iff (rst)
    (!ld && inc && lin_addr == LW'(TOTAL-1)) |=> (lin_addr == '0 && end_around));
  p_wrap_dn_r6: assert property (@(posedge clk) disable iff (rst)
    (!ld && !inc && dec && lin_addr == '0) |=> (lin_addr == LW'(TOTAL-1) && end_around));
  p_ea_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (ld || !(inc || dec)) |=> !end_around);
  // R8: above installed size is flagged
  p_size_r8: assert property (@(posedge clk) disable iff (rst)
    (32'(lin_addr) >= (TOTAL/4) * (32'($past(size_sel)) + 1)) |-> bad_addr);
  // R9: idle holds the address
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ld && !inc && !dec) |=> ($stable(lin_addr) && $stable(addr_chars)));
  // R2: linear value stays in range
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    32'(lin_addr) < TOTAL);
endmodule

// File: tb/test_zaddr_reg.sv
module test_zaddr_reg;
  logic clk = 1'b0;
  logic rst, ld, inc, dec;
  logic [17:0] ld_addr;
  logic [1:0]  size_sel;
  logic [13:0] lin_addr;
  logic [17:0] addr_chars;
  logic bad_addr, end_around;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  zaddr_reg i_zaddr_reg (.clk(clk), .rst(rst), .ld(ld), .ld_addr(ld_addr), .inc(inc),
    .dec(dec), .size_sel(size_sel), .lin_addr(lin_addr), .addr_chars(addr_chars),
    .bad_addr(bad_addr), .end_around(end_around));

  function automatic logic [3:0] cd(int v);
    return (v == 0) ? 4'd10 : 4'(v);
  endfunction

  function automatic logic [17:0] enc(int a);
    int blk, r, th;
    blk = a / 4000; r = a % 4000; th = r / 1000;
    return {2'(th), cd((r/100)%10), 2'b00, cd((r/10)%10), 2'(blk), cd(r%10)};
  endfunction

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic op(logic l, logic i, logic d, logic [17:0] a);
    @(negedge clk);
    ld = l; inc = i; dec = d; ld_addr = a;
    @(negedge clk);
    ld = 0; inc = 0; dec = 0;
  endtask

  task automatic expect_addr(string req, int a, logic b, logic e);
    chk({req, " lin"}, int'(lin_addr), a);
    chk({req, " chars"}, int'(addr_chars), int'(enc(a)));
    chk({req, " bad"}, int'(bad_addr), int'(b));
    chk({req, " ea"}, int'(end_around), int'(e));
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_addr("R1", 0, 1'b0, 1'b0);
  endtask

  task automatic t_load;
    int v [10] = '{0, 999, 1000, 2345, 3999, 4000, 7999, 8123, 12000, 15999};
    size_sel = 2'd3;
    foreach (v[k]) begin
      op(1, 0, 0, enc(v[k]));
      expect_addr((v[k] < 4000) ? "R2" : "R3", v[k], 1'b0, 1'b0);
    end
  endtask

  task automatic t_steps;
    op(1, 0, 0, enc(999));  op(0, 1, 0, '0); expect_addr("R4", 1000, 0, 0);
    op(1, 0, 0, enc(3999)); op(0, 1, 0, '0); expect_addr("R4", 4000, 0, 0);
    op(1, 0, 0, enc(11999)); op(0, 1, 0, '0); expect_addr("R4", 12000, 0, 0);
    op(1, 0, 0, enc(1000)); op(0, 0, 1, '0); expect_addr("R5", 999, 0, 0);
    op(1, 0, 0, enc(8000)); op(0, 0, 1, '0); expect_addr("R5", 7999, 0, 0);
  endtask

  task automatic t_wrap;
    op(1, 0, 0, enc(15999)); op(0, 1, 0, '0); expect_addr("R6", 0, 0, 1);
    op(0, 0, 0, '0); expect_addr("R6", 0, 0, 0);
    op(0, 0, 1, '0); expect_addr("R6", 15999, 0, 1);
    op(0, 0, 1, '0); expect_addr("R6", 15998, 0, 0);
  endtask

  task automatic t_illegal;
    logic [17:0] a;
    a = enc(105); a[9:6] = 4'd0;
    op(1, 0, 0, a);
    chk("R7 bad 0000", int'(bad_addr), 1);
    chk("R7 value", int'(lin_addr), 105);
    op(0, 1, 0, '0); expect_addr("R7", 106, 0, 0);
    a = enc(2468); a[3:0] = 4'd11;
    op(1, 0, 0, a); chk("R7 bad 1011", int'(bad_addr), 1);
    a = enc(2468); a[10] = 1'b1;
    op(1, 0, 0, a); chk("R7 tens zone", int'(bad_addr), 1);
  endtask

  task automatic t_size;
    size_sel = 2'd0;
    op(1, 0, 0, enc(4000)); chk("R8 size0 4000", int'(bad_addr), 1);
    op(1, 0, 0, enc(3999)); chk("R8 size0 3999", int'(bad_addr), 0);
    op(0, 1, 0, '0);        chk("R8 step over", int'(bad_addr), 1);
    size_sel = 2'd2;
    op(1, 0, 0, enc(12000)); chk("R8 size2 12000", int'(bad_addr), 1);
    op(1, 0, 0, enc(11999)); chk("R8 size2 11999", int'(bad_addr), 0);
    op(1, 0, 0, enc(12000));
    @(negedge clk); size_sel = 2'd3;
    @(negedge clk); chk("R8 size change", int'(bad_addr), 0);
    chk("R8 hold value", int'(lin_addr), 12000);
  endtask

  task automatic t_prio;
    op(1, 0, 0, enc(500));
    op(1, 1, 1, enc(7000)); expect_addr("R9 ld wins", 7000, 0, 0);
    op(0, 1, 1, '0);        expect_addr("R9 inc wins", 7001, 0, 0);
    op(0, 0, 0, enc(3));    expect_addr("R9 hold", 7001, 0, 0);
    @(negedge clk); ld = 1; ld_addr = enc(42);
    @(posedge clk); #1;
    chk("R10 same edge", int'(lin_addr), 42);
    @(negedge clk); ld = 0;
  endtask

  initial begin
    rst = 1; ld = 0; inc = 0; dec = 0; ld_addr = '0; size_sel = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_load();
    t_steps();
    t_wrap();
    t_illegal();
    t_size();
    t_prio();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule